// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block paces one programmed-I/O access on a two-drive IDE channel, counting every phase in bus clocks. A host request names the target drive (master or slave), the direction (read or write) and the width (16-bit data or 8-bit register access). The block first holds the address stable for a setup period. It then drives the read or write strobe for an active period. Last, it waits a recovery period before it will take another request. The length of each phase comes from a small set of configuration registers. Each drive has its own setup count, and each drive and access kind has its own active/recovery byte.

The request side is a valid/ready interface. `req_ready` is high only while the block is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. While `req_ready` is low, the host must hold its request, or withdraw it; nothing is queued. The completion side has no back-pressure: `done` pulses for one clock, and `rd_data` keeps the sampled read value until the next read completes. The timing values are captured when a request is accepted, so reprogramming never disturbs an access already in flight.

Top module: `ide_pio_timer`

## Requirements
- R1: A synchronous active-high reset loads every 4-bit count field with 4'hF and returns the block to idle. Idle means `req_ready`=1, `busy`=0 and both strobes low, so the first access after reset takes 16 clocks in each phase.
- R2: A request is accepted on an edge where `req_valid` and `req_ready` are both high. `busy` is high from the next clock until the last recovery clock. `req_ready` is high exactly when `busy` is low.
- R3: After acceptance, the setup phase (busy, no strobe) lasts S+1 clocks. S is bits [3:0] of config offset 0 for the master (`req_drive`=0) and bits [7:4] of offset 0 for the slave (`req_drive`=1).
- R4: The strobe phase lasts A+1 clocks, where A is bits [7:4] of the selected timing byte.
- R5: After the strobe drops, recovery lasts R+1 clocks, where R is bits [3:0] of the selected timing byte. `req_ready` returns on the clock after recovery.
- R6: The timing byte is chosen by drive and kind. Master: offset 1 for 16-bit read, 2 for 16-bit write, 3 for 8-bit access (`req_wide`=0). Slave: offsets 4, 5 and 6 for the same kinds.
- R7: Reads (`req_write`=0) drive only `strobe_rd`, writes drive only `strobe_wr`, and the two are never high together.
- R8: On a read, `ide_rd_data` is sampled on the edge that ends the last strobe clock. On the following clock, `done` is high for exactly one cycle and `rd_data` holds the sample. An 8-bit read zero-fills `rd_data[15:8]`. A write also pulses `done` at the same point.
- R9: A config write made while an access is in progress does not change that access's timing; it applies from the next accepted request.
- R10: `addr_phase` is high during setup and strobe clocks. `drive_sel` and `wide_sel` stay unchanged for the whole busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config register write enable |
| cfg_addr | input | 3 | Config register offset |
| cfg_wdata | input | 8 | Config write data |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block idle and able to accept |
| req_drive | input | 1 | 0 = master, 1 = slave |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 16-bit data, 0 = 8-bit register |
| ide_rd_data | input | 16 | Data bus from the drive |
| busy | output | 1 | Access in progress |
| addr_phase | output | 1 | Address must be held (setup and strobe) |
| drive_sel | output | 1 | Drive of the current access |
| wide_sel | output | 1 | Width of the current access |
| strobe_rd | output | 1 | Read strobe, active high |
| strobe_wr | output | 1 | Write strobe, active high |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Latched read data |

## Verification
The bench sweeps every drive/kind pairing across several programming rounds. In each round, all six timing bytes and both setup nibbles hold different values, so a wrong register choice or a swapped nibble shows up as a wrong phase length. One round sets every field to zero, to exercise single-clock phases, and the reset run exercises the all-ones maximum. The read bus changes every clock, so the value reported on `done` pins down which strobe clock was sampled. A separate access rewrites its own timing registers mid-flight, which separates "captured at acceptance" from "read live".

// File: rtl/ide_pio_pkg.sv
package ide_pio_pkg;
  localparam int CNT_W      = 4;
  localparam int BYTE_W     = 2 * CNT_W;
  localparam int NUM_DRIVES = 2;
  localparam int NUM_KINDS  = 3;
  localparam int NUM_TIM    = NUM_DRIVES * NUM_KINDS;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_SETUP   = 2'd1,
    ST_ACTIVE  = 2'd2,
    ST_RECOVER = 2'd3
  } seq_state_e;

  typedef enum logic [1:0] {
    KIND_RD16 = 2'd0,
    KIND_WR16 = 2'd1,
    KIND_BYTE = 2'd2
  } access_kind_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] recover;
  } timing_t;

  // offset 0 is the shared setup register, timing bytes follow
  function automatic int tim_offset(input int drive, input int kind);
    return 1 + drive * NUM_KINDS + kind;
  endfunction
endpackage

// File: rtl/ide_pio_cfg_regs.sv
module ide_pio_cfg_regs
  import ide_pio_pkg::*;
#(
  parameter int CFG_AW = 3
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [BYTE_W-1:0]             cfg_wdata,
  output logic [NUM_DRIVES*CNT_W-1:0]   setup_o,
  output logic [NUM_TIM*BYTE_W-1:0]     tim_o
);
  localparam logic [CFG_AW-1:0] SETUP_OFS = '0;

  // shared setup register: drive d owns nibble d
  always_ff @(posedge clk) begin
    if (rst) begin
      setup_o <= '1;
    end else if (cfg_we && cfg_addr == SETUP_OFS) begin
      setup_o <= cfg_wdata[NUM_DRIVES*CNT_W-1:0];
    end
  end

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drive
    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
      localparam int IDX = d * NUM_KINDS + k;
      localparam logic [CFG_AW-1:0] OFS = CFG_AW'(tim_offset(d, k));
      always_ff @(posedge clk) begin
        if (rst) begin
          tim_o[IDX*BYTE_W +: BYTE_W] <= '1;
        end else if (cfg_we && cfg_addr == OFS) begin
          tim_o[IDX*BYTE_W +: BYTE_W] <= cfg_wdata;
        end
      end
    end
  end
endmodule

// File: rtl/ide_pio_timing_sel.sv
module ide_pio_timing_sel
  import ide_pio_pkg::*;
(
  input  logic                        drive,
  input  access_kind_e                kind,
  input  logic [NUM_DRIVES*CNT_W-1:0] setup_i,
  input  logic [NUM_TIM*BYTE_W-1:0]   tim_i,
  output timing_t                     timing_o
);
  logic [BYTE_W-1:0] tim_byte;
  int                idx;

  always_comb begin
    idx      = int'(drive) * NUM_KINDS + int'(kind);
    tim_byte = tim_i[idx*BYTE_W +: BYTE_W];
    timing_o.setup   = setup_i[int'(drive)*CNT_W +: CNT_W];
    timing_o.active  = tim_byte[BYTE_W-1:CNT_W];
    timing_o.recover = tim_byte[CNT_W-1:0];
  end
endmodule

// File: rtl/ide_pio_seq.sv
module ide_pio_seq
  import ide_pio_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_drive,
  input  logic              req_write,
  input  logic              req_wide,
  input  timing_t           timing_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic              busy,
  output logic              addr_phase,
  output logic              drive_sel,
  output logic              wide_sel,
  output logic              strobe_rd,
  output logic              strobe_wr,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NARROW_W = 8;

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_q;
  logic [CNT_W-1:0] rec_q;
  logic             write_q;
  logic             accept;
  logic             cnt_zero;

  assign accept   = req_valid && (state_q == ST_IDLE);
  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '1;
      act_q     <= '1;
      rec_q     <= '1;
      write_q   <= 1'b0;
      drive_sel <= 1'b0;
      wide_sel  <= 1'b0;
      done      <= 1'b0;
      rd_data   <= '0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            state_q   <= ST_SETUP;
            cnt_q     <= timing_i.setup;
            act_q     <= timing_i.active;
            rec_q     <= timing_i.recover;
            write_q   <= req_write;
            drive_sel <= req_drive;
            wide_sel  <= req_wide;
          end
        end
        ST_SETUP: begin
          if (cnt_zero) begin
            state_q <= ST_ACTIVE;
            cnt_q   <= act_q;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (cnt_zero) begin
            state_q <= ST_RECOVER;
            cnt_q   <= rec_q;
            done    <= 1'b1;
            if (!write_q) begin
              rd_data <= wide_sel ? bus_i
                                  : {{(DATA_W-NARROW_W){1'b0}}, bus_i[NARROW_W-1:0]};
            end
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_RECOVER: begin
          if (cnt_zero) begin
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready  = (state_q == ST_IDLE);
  assign busy       = (state_q != ST_IDLE);
  assign addr_phase = (state_q == ST_SETUP) || (state_q == ST_ACTIVE);
  assign strobe_rd  = (state_q == ST_ACTIVE) && !write_q;
  assign strobe_wr  = (state_q == ST_ACTIVE) &&  write_q;
endmodule

// File: rtl/ide_pio_timer.sv
module ide_pio_timer
  import ide_pio_pkg::*;
#(
  parameter int CFG_AW = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_drive,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [DATA_W-1:0] ide_rd_data,
  output logic              busy,
  output logic              addr_phase,
  output logic              drive_sel,
  output logic              wide_sel,
  output logic              strobe_rd,
  output logic              strobe_wr,
  output logic              done,
  output logic [DATA_W-1:0] rd_data
);
  logic [NUM_DRIVES*CNT_W-1:0] setup_w;
  logic [NUM_TIM*BYTE_W-1:0]   tim_w;
  access_kind_e                kind_w;
  timing_t                     timing_w;

  always_comb begin
    if (!req_wide)      kind_w = KIND_BYTE;
    else if (req_write) kind_w = KIND_WR16;
    else                kind_w = KIND_RD16;
  end

  ide_pio_cfg_regs #(.CFG_AW(CFG_AW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .setup_o   (setup_w),
    .tim_o     (tim_w)
  );

  ide_pio_timing_sel u_sel (
    .drive    (req_drive),
    .kind     (kind_w),
    .setup_i  (setup_w),
    .tim_i    (tim_w),
    .timing_o (timing_w)
  );

  ide_pio_seq #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_drive  (req_drive),
    .req_write  (req_write),
    .req_wide   (req_wide),
    .timing_i   (timing_w),
    .bus_i      (ide_rd_data),
    .busy       (busy),
    .addr_phase (addr_phase),
    .drive_sel  (drive_sel),
    .wide_sel   (wide_sel),
    .strobe_rd  (strobe_rd),
    .strobe_wr  (strobe_wr),
    .done       (done),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/ide_pio_timer_chk.sv
module ide_pio_timer_chk (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic addr_phase,
  input logic drive_sel,
  input logic wide_sel,
  input logic strobe_rd,
  input logic strobe_wr,
  input logic done
);
  p_strobe_excl_r7: assert property (@(posedge clk) disable iff (rst)
    !(strobe_rd && strobe_wr));

  p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> busy);

  p_strobe_in_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe_rd || strobe_wr) |-> (busy && addr_phase));

  p_done_after_rd_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_rd) |-> done);

  p_done_after_wr_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(strobe_wr) |-> done);

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_hold_drive_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(drive_sel) && $stable(wide_sel)));
endmodule

bind ide_pio_timer ide_pio_timer_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .busy       (busy),
  .addr_phase (addr_phase),
  .drive_sel  (drive_sel),
  .wide_sel   (wide_sel),
  .strobe_rd  (strobe_rd),
  .strobe_wr  (strobe_wr),
  .done       (done)
);

// File: tb/ide_pio_timer_tb_top.sv
module ide_pio_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_drive = 1'b0;
  logic        req_write = 1'b0;
  logic        req_wide = 1'b0;
  logic [15:0] ide_rd_data = '0;
  logic        busy, addr_phase, drive_sel, wide_sel, strobe_rd, strobe_wr, done;
  logic [15:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ide_pio_timer dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_drive(req_drive),
    .req_write(req_write), .req_wide(req_wide), .ide_rd_data(ide_rd_data),
    .busy(busy), .addr_phase(addr_phase), .drive_sel(drive_sel), .wide_sel(wide_sel),
    .strobe_rd(strobe_rd), .strobe_wr(strobe_wr), .done(done), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // runs one access; optionally writes a config register on the first busy clock
  task automatic run_xfer(input logic d, input logic wr, input logic wd,
                          input int es, input int ea, input int er,
                          input bit mid_we, input logic [2:0] mid_a, input logic [7:0] mid_d);
    int pre = 0, act = 0, post = 0, dn = 0, wrong = 0, holdbad = 0, cyc = 0;
    logic [15:0] last_bus = '0, got = '0, expd;
    @(negedge clk);
    req_valid = 1'b1; req_drive = d; req_write = wr; req_wide = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (busy && cyc < 200) begin
      ide_rd_data = 16'h3C00 + 16'(cyc * 16'h0107);
      if (cyc == 0 && mid_we) begin cfg_we = 1'b1; cfg_addr = mid_a; cfg_wdata = mid_d; end
      else cfg_we = 1'b0;
      if (strobe_rd || strobe_wr) begin act++; last_bus = ide_rd_data; end
      else if (act == 0) pre++;
      else post++;
      if (wr ? strobe_rd : strobe_wr) wrong++;
      if (drive_sel != d || wide_sel != wd) holdbad++;
      if ((strobe_rd || strobe_wr) && !addr_phase) holdbad++;
      if (done) begin dn++; got = rd_data; end
      @(negedge clk);
      cyc++;
    end
    cfg_we = 1'b0;
    check(pre == es + 1, "R3 setup length", pre, es + 1);
    check(act == ea + 1, "R4 strobe length", act, ea + 1);
    check(post == er + 1, "R5 recovery length", post, er + 1);
    check(req_ready == 1'b1, "R5 ready after recovery", int'(req_ready), 1);
    check(wrong == 0, "R7 strobe direction", wrong, 0);
    check(holdbad == 0, "R10 select hold", holdbad, 0);
    check(dn == 1, "R8 done pulse count", dn, 1);
    if (!wr) begin
      expd = wd ? last_bus : {8'h00, last_bus[7:0]};
      check(got == expd, "R8 read data", int'(got), int'(expd));
    end
  endtask

  function automatic int f_act(input int t, input int i);
    return (t == 6) ? 0 : (t * 5 + i * 3 + 1) % 16;
  endfunction
  function automatic int f_rec(input int t, input int i);
    return (t == 6) ? 0 : (t * 7 + i * 2 + 3) % 16;
  endfunction
  function automatic int f_set(input int t, input int d);
    return (t == 6) ? 0 : (d == 0 ? (t * 3 + 2) % 16 : (t * 11 + 5) % 16);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after reset
    check(req_ready == 1'b1, "R1 ready at reset", int'(req_ready), 1);
    check(busy == 1'b0, "R1 busy at reset", int'(busy), 0);
    check(!strobe_rd && !strobe_wr, "R1 strobes at reset", int'(strobe_rd | strobe_wr), 0);
    // R1: reset counts are all 4'hF
    run_xfer(1'b1, 1'b0, 1'b1, 15, 15, 15, 1'b0, 3'd0, 8'd0);

    // R2 R3 R4 R5 R6 sweep over drives and kinds
    for (int t = 0; t < 7; t++) begin
      cfg_write(3'd0, 8'((f_set(t, 1) << 4) | f_set(t, 0)));
      for (int i = 0; i < 6; i++)
        cfg_write(3'(i + 1), 8'((f_act(t, i) << 4) | f_rec(t, i)));
      for (int d = 0; d < 2; d++) begin
        for (int k = 0; k < 3; k++) begin
          logic wr, wd;
          int i;
          wr = (k == 1);
          wd = (k != 2);
          i = d * 3 + k;
          // for the byte kind, alternate direction by round
          if (k == 2) wr = t[0];
          run_xfer(1'(d), wr, wd, f_set(t, d), f_act(t, i), f_rec(t, i), 1'b0, 3'd0, 8'd0);
        end
      end
    end

    // R9: mid-transfer rewrite of the live timing byte and setup register
    cfg_write(3'd0, 8'h21);
    cfg_write(3'd1, 8'h23);
    run_xfer(1'b0, 1'b0, 1'b1, 1, 2, 3, 1'b1, 3'd1, 8'h51);
    run_xfer(1'b0, 1'b0, 1'b1, 1, 5, 1, 1'b0, 3'd0, 8'd0);
    run_xfer(1'b0, 1'b0, 1'b1, 1, 5, 1, 1'b1, 3'd0, 8'h24);
    run_xfer(1'b0, 1'b0, 1'b1, 4, 5, 1, 1'b0, 3'd0, 8'd0);

    // R2: held request waits for ready and is taken exactly once
    @(negedge clk);
    req_valid = 1'b1; req_drive = 1'b0; req_write = 1'b1; req_wide = 1'b1;
    @(negedge clk);
    check(busy == 1'b1 && req_ready == 1'b0, "R2 ready low while busy", int'(req_ready), 0);
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    check(req_ready == 1'b1, "R2 ready with busy low", int'(req_ready), 1);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule